// File: doc/BRIEF.md
# Indexed segmented dot-product accumulator

This block is a vector datapath stage that performs an unsigned, indexed dot-product-accumulate over a vector whose width is a multiple of 128 bits. It works in one of two lane modes. In narrow mode every 32-bit accumulator lane takes four unsigned bytes from the first operand. In wide mode every 64-bit lane takes four unsigned 16-bit values from the first operand. Each lane multiplies its four values by one group of four values from the second operand and adds the products to its accumulator lane. That second-operand group is chosen by an immediate index that is applied separately inside each 128-bit segment. Every lane in a segment therefore shares the same group, and that group is taken from that segment only.

Operands enter through a valid/ready handshake. The result leaves, one clock after acceptance, through a second valid/ready handshake. The input is accepted when `in_valid` and `in_ready` are both high at a rising edge. `in_ready` is high while the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its value and no new input is taken. A consumer that keeps `out_ready` high gets one result per cycle.

Top module: `dotp_idx_acc`

## Requirements
- R1: With `wide_mode`=0, lane k (bits 32k+31..32k) of `result` equals that lane of `acc_in` plus the sum of the four products of bytes 4k+j of `src_a` with bytes 4g+j of `src_b`, for j=0..3. Here g is the group number defined in R3.
- R2: With `wide_mode`=1, lane k (64 bits) of `result` equals that lane of `acc_in` plus the sum of the four products of 16-bit values 4k+j of `src_a` with 16-bit values 4g+j of `src_b`, for j=0..3.
- R3: The second-operand group for lane k is g = (k − (k mod L)) + index, where L is 4 in narrow mode and 2 in wide mode. Each 128-bit segment therefore uses its own indexed group.
- R4: In wide mode only bit 0 of `grp_idx` is used. Bit 1 has no effect on `result`.
- R5: All operands are unsigned, and each lane sum is truncated to the lane width, so it wraps modulo 2^32 or 2^64.
- R6: Every lane of the vector is updated on each accepted operation. No lane is masked.
- R7: After an input is accepted at a rising edge, `out_valid` is high and `result` holds the new value from that edge onward.
- R8: A synchronous active-high `rst` clears `out_valid`, after which `in_ready` is high.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0, and both `out_valid` and `result` stay unchanged.
- R10: When `out_valid`=1 and `out_ready`=1, `in_ready` is 1, so a new input is accepted in the same cycle that the previous result is taken. With `out_ready` held high, results stream at one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set is offered |
| in_ready | output | 1 | Block can take an operand set |
| wide_mode | input | 1 | 0: 32-bit lanes of bytes, 1: 64-bit lanes of halfwords |
| grp_idx | input | 2 | Per-segment group index (bit 1 ignored in wide mode) |
| src_a | input | VEC_W | First operand vector |
| src_b | input | VEC_W | Second operand vector (indexed groups) |
| acc_in | input | VEC_W | Accumulator vector |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| result | output | VEC_W | Accumulated result vector |

## Verification
Draining a result and accepting the next operand set can fall in the same cycle. The bench provokes this by streaming operand sets back to back with `out_ready` held high, and later with `out_ready` toggled at random. A scoreboard judges both cases: each result must match its own queued reference entry in order, with none lost or repeated. During stalls the held result must stay fixed and `in_ready` must stay low.

// File: rtl/dotp_pkg.sv
package dotp_pkg;
  typedef enum logic {
    LANES_NARROW = 1'b0,
    LANES_WIDE   = 1'b1
  } lane_mode_e;

  localparam int SEG_W  = 128;
  localparam int GROUP  = 4;
endpackage

// File: rtl/dotp_lane.sv
// One accumulator lane: acc + sum of four elementwise unsigned products,
// truncated to the lane width (wraps).
module dotp_lane #(
  parameter int EW = 8
) (
  input  logic [4*EW-1:0] a_grp,
  input  logic [4*EW-1:0] b_grp,
  input  logic [4*EW-1:0] acc,
  output logic [4*EW-1:0] sum
);
  localparam int LW = 4 * EW;

  logic [LW-1:0] run;

  always_comb begin
    run = acc;
    for (int j = 0; j < dotp_pkg::GROUP; j++) begin
      run = run + (LW'(a_grp[j*EW +: EW]) * LW'(b_grp[j*EW +: EW]));
    end
  end

  assign sum = run;
endmodule

// File: rtl/dotp_segment.sv
// One 128-bit segment: selects the indexed group of the second operand
// inside this segment and feeds both lane variants; mode picks the output.
module dotp_segment
  import dotp_pkg::*;
(
  input  lane_mode_e         mode,
  input  logic [1:0]         idx,
  input  logic [SEG_W-1:0]   a_seg,
  input  logic [SEG_W-1:0]   b_seg,
  input  logic [SEG_W-1:0]   acc_seg,
  output logic [SEG_W-1:0]   res_seg
);
  localparam int N_NARROW = SEG_W / 32;
  localparam int N_WIDE   = SEG_W / 64;

  logic [31:0]      b_pick32;
  logic [63:0]      b_pick64;
  logic [SEG_W-1:0] res_narrow;
  logic [SEG_W-1:0] res_wide;

  assign b_pick32 = b_seg[{idx, 5'b0} +: 32];
  assign b_pick64 = b_seg[{idx[0], 6'b0} +: 64];

  for (genvar k = 0; k < N_NARROW; k++) begin : g_narrow
    dotp_lane #(.EW(8)) u_lane (
      .a_grp (a_seg[k*32 +: 32]),
      .b_grp (b_pick32),
      .acc   (acc_seg[k*32 +: 32]),
      .sum   (res_narrow[k*32 +: 32])
    );
  end

  for (genvar k = 0; k < N_WIDE; k++) begin : g_wide
    dotp_lane #(.EW(16)) u_lane (
      .a_grp (a_seg[k*64 +: 64]),
      .b_grp (b_pick64),
      .acc   (acc_seg[k*64 +: 64]),
      .sum   (res_wide[k*64 +: 64])
    );
  end

  assign res_seg = (mode == LANES_WIDE) ? res_wide : res_narrow;
endmodule

// File: rtl/dotp_idx_acc.sv
module dotp_idx_acc
  import dotp_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             wide_mode,
  input  logic [1:0]       grp_idx,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [VEC_W-1:0] acc_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] result
);
  localparam int N_SEG = VEC_W / SEG_W;

  lane_mode_e       mode;
  logic [VEC_W-1:0] next_res;
  logic             take;

  assign mode = lane_mode_e'(wide_mode);

  for (genvar s = 0; s < N_SEG; s++) begin : g_seg
    dotp_segment u_seg (
      .mode    (mode),
      .idx     (grp_idx),
      .a_seg   (src_a[s*SEG_W +: SEG_W]),
      .b_seg   (src_b[s*SEG_W +: SEG_W]),
      .acc_seg (acc_in[s*SEG_W +: SEG_W]),
      .res_seg (next_res[s*SEG_W +: SEG_W])
    );
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      result <= next_res;
    end
  end

  // Accepted input shows up as a valid result on the next cycle.
  p_accept_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // Stalled output keeps value and flag.
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(result));

  // Drained without a new offer empties the register.
  p_drain_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !in_valid |=> !out_valid);

  // Drain and refill in one cycle keeps the stream going.
  p_chain_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && in_valid |=> out_valid);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // Reset leaves the output register empty.
  always @(posedge clk) begin
    if (rst_q && !rst) begin
      p_reset_r8: assert (!out_valid);
    end
  end
endmodule

// File: tb/dotp_idx_acc_test.sv
`timescale 1ns/1ps
module dotp_idx_acc_test;
  localparam int VW = 256;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic          in_ready;
  logic          wide_mode;
  logic [1:0]    grp_idx;
  logic [VW-1:0] src_a, src_b, acc_in;
  logic          out_valid;
  logic          out_ready;
  logic [VW-1:0] result;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int rdy_rand = 0;

  logic [VW-1:0] exp_q[$];
  string         tag_q[$];

  always #5 clk = ~clk;

  dotp_idx_acc #(.VEC_W(VW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .wide_mode(wide_mode), .grp_idx(grp_idx), .src_a(src_a), .src_b(src_b),
    .acc_in(acc_in), .out_valid(out_valid), .out_ready(out_ready),
    .result(result)
  );

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int k = 0; k < VW/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  // Reference: g = (k - k mod L) + index, products summed in order, wraps.
  function automatic logic [VW-1:0] ref_calc(logic m, logic [1:0] ix,
      logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] c);
    logic [VW-1:0] r;
    int esz, sub, lanes, eps, use_ix;
    logic [63:0] msk, lmsk, acc, ea, eb;
    esz    = m ? 64 : 32;
    sub    = esz / 4;
    lanes  = VW / esz;
    eps    = 128 / esz;
    use_ix = m ? int'(ix[0]) : int'(ix);
    msk    = (64'd1 << sub) - 64'd1;
    lmsk   = m ? {64{1'b1}} : 64'h0000_0000_FFFF_FFFF;
    r = '0;
    for (int e = 0; e < lanes; e++) begin
      int s;
      s   = e - (e % eps) + use_ix;
      acc = 64'(c >> (e*esz)) & lmsk;
      for (int i = 0; i < 4; i++) begin
        ea  = 64'(a >> ((4*e+i)*sub)) & msk;
        eb  = 64'(b >> ((4*s+i)*sub)) & msk;
        acc = (acc + ea * eb) & lmsk;
      end
      r = r | (VW'(acc) << (e*esz));
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Consumer side: ready pattern
  always @(negedge clk) begin
    out_ready <= (rdy_rand != 0) ? 1'($urandom % 2) : 1'b1;
  end

  // Driver: offers one operand set, pushes its expectation when accepted.
  task automatic send(logic m, logic [1:0] ix, logic [VW-1:0] a,
                      logic [VW-1:0] b, logic [VW-1:0] c, string tag);
    @(negedge clk);
    in_valid = 1'b1; wide_mode = m; grp_idx = ix;
    src_a = a; src_b = b; acc_in = c;
    #2;
    while (!in_ready) begin
      check(!(out_valid && out_ready), "R10", VW'(in_ready), VW'(1));
      check(out_valid, "R9", VW'(out_valid), VW'(1));
      @(negedge clk); #2;
    end
    if (out_valid && out_ready)
      check(in_ready == 1'b1, "R10", VW'(in_ready), VW'(1));
    exp_q.push_back(ref_calc(m, ix, a, b, c));
    tag_q.push_back(tag);
    @(posedge clk); #1;
    check(out_valid == 1'b1, "R7", VW'(out_valid), VW'(1));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  logic          was_stalled = 0;
  logic [VW-1:0] held;
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (was_stalled) begin
        check(out_valid && result == held, "R9", result, held);
      end
      was_stalled = out_valid && !out_ready;
      held        = result;
      if (was_stalled) check(!in_ready, "R9", VW'(in_ready), VW'(0));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", result, '0);
        end else begin
          logic [VW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(result == e, t, result, e);
        end
      end
    end
  end

  initial begin
    #(1_000_000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] ones, a, b;
    ones = '1;
    rst = 1'b1; in_valid = 1'b0; wide_mode = 1'b0; grp_idx = 2'd0;
    src_a = '0; src_b = '0; acc_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #2;
    check(out_valid == 1'b0, "R8", VW'(out_valid), VW'(0));
    check(in_ready == 1'b1, "R8", VW'(in_ready), VW'(1));

    // narrow mode, every index value
    for (int ix = 0; ix < 4; ix++) send(1'b0, 2'(ix), rnd_vec(), rnd_vec(), rnd_vec(), "R1");
    // segments with distinct second operand groups, small values to spot misplacement
    for (int ix = 0; ix < 4; ix++) begin
      b = '0;
      for (int k = 0; k < VW/8; k++) b[k*8 +: 8] = 8'(k + 1);
      send(1'b0, 2'(ix), rnd_vec(), b, '0, "R3");
      send(1'b1, 2'(ix % 2), rnd_vec(), b, '0, "R3");
    end
    // wide mode
    for (int ix = 0; ix < 2; ix++) send(1'b1, 2'(ix), rnd_vec(), rnd_vec(), rnd_vec(), "R2");
    // wide mode, upper index bit set
    a = rnd_vec(); b = rnd_vec();
    send(1'b1, 2'd2, a, b, '0, "R4");
    send(1'b1, 2'd3, a, b, '0, "R4");
    // wraparound
    send(1'b0, 2'd1, ones, ones, ones, "R5");
    send(1'b1, 2'd1, ones, ones, ones, "R5");
    send(1'b0, 2'd3, ones, rnd_vec(), ones - VW'(5), "R5");
    // all lanes touched
    send(1'b0, 2'd2, rnd_vec(), rnd_vec(), rnd_vec(), "R6");
    send(1'b1, 2'd0, rnd_vec(), rnd_vec(), rnd_vec(), "R6");
    idle();
    repeat (3) @(negedge clk);

    // random back-pressure
    rdy_rand = 1;
    for (int n = 0; n < 40; n++)
      send(1'($urandom % 2), 2'($urandom % 4), rnd_vec(), rnd_vec(), rnd_vec(), "R9");
    idle();
    while (exp_q.size() != 0) @(negedge clk);
    rdy_rand = 0;
    @(negedge clk);

    // streaming with consumer always ready
    for (int n = 0; n < 20; n++)
      send(1'($urandom % 2), 2'($urandom % 4), rnd_vec(), rnd_vec(), rnd_vec(), "R10");
    idle();
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10", VW'(exp_q.size()), VW'(0));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule